// File: doc/BRIEF.md
# Byte-Level Serial Bus Target with Bit-Bang Controller Pins

This block is a memory-mapped two-wire serial bus peripheral for a small microcontroller. On the bus side it has open-drain clock and data lines, each with a raw input and an active-high pull-low enable. On the CPU side it has a simple register port with an address, write data, registered read data, a write strobe and a read strobe. The port reaches three registers: control/status, own address and data.

In target mode, hardware does the bus work. It detects START and STOP, matches the 7-bit address, drives the acknowledge, shifts bytes in and out, and raises an interrupt after every byte. In controller mode, the hardware target is parked. Software then toggles the data and clock lines directly through control bits, and the block only drives the pins and latches the data line on clock rising edges. A software reset bit holds the target engine idle. The interrupt flag clears itself whenever software touches the data register.

Top module: `i2c_periph`

## Requirements
- R1: After reset, control reads 0x00, own address reads 0x55, data reads 0x00, `irq` is 0, and neither `sda_oe` nor `scl_oe` is asserted.
- R2: Register addresses are 0 for control, 1 for own address (7 bits in [6:0], bit 7 reads 0) and 2 for data. `reg_rdata` is valid in the cycle after `reg_rd`. In control, software may write bits 7, 6, 5, 3 and 2. Bits 4, 1 and 0 are hardware-owned and ignore writes.
- R3: With control bit 3 (controller mode) at 1, `scl_oe` equals the inverse of bit 5 (clock out). `sda_oe` equals bit 6 (data enable) AND NOT bit 7 (data out). Both follow within two cycles of the write.
- R4: In controller mode with bit 6 at 0, the data line is latched into control bit 4 on each clock-line rising edge. With bit 6 at 1, bit 4 holds its value.
- R5: While control bit 2 (engine reset) is 1, the target ignores all bus traffic and gives no acknowledge. It answers normally once the bit is cleared.
- R6: The first byte after START is taken MSB first on clock rising edges as a 7-bit address followed by an R/W bit (1 = read). On a match the target pulls data low for the ninth clock. On a mismatch it never drives data until the next START.
- R7: In a write transfer, each data byte is acknowledged, stored in the data register and sets the interrupt flag.
- R8: In a read transfer, the data register value is driven MSB first, and the data line changes only while the clock is low. Control bit 1 reads 1 from the address match until the controller NACKs, which returns the target to idle and clears bit 1.
- R9: The interrupt flag (control bit 0, mirrored on `irq`) is set after every data byte sent or received. Any read or write of the data register clears it.
- R10: A STOP returns the target to idle, so bits that follow without a START are not acknowledged. A repeated START restarts the address phase even in the middle of a byte.
- R11: In target mode the block never asserts `scl_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Byte-complete interrupt |
| scl_i | input | 1 | Clock line as seen on the bus |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_i | input | 1 | Data line as seen on the bus |
| sda_oe | output | 1 | Pull data line low when 1 |

## Verification
Several properties are checked on every cycle. In controller mode the pin enables follow the control bits, and the clock line is never pulled in target mode. The engine-reset bit silences the data line. The flag sets on every byte event and drops after a data-register access, and the data line holds steady while the clock is high during a read. Other behaviour only shows up in the bench's bus scenarios: address matching across the full 7-bit space, correct byte values in both directions, NACK and STOP ending a transfer, and a repeated START cutting into a partial byte.

// File: rtl/i2c_periph_pkg.sv
package i2c_periph_pkg;
  localparam int RA_W = 2;
  localparam logic [RA_W-1:0] RA_CTRL = 2'd0;
  localparam logic [RA_W-1:0] RA_OWN  = 2'd1;
  localparam logic [RA_W-1:0] RA_DATA = 2'd2;

  // control register bit positions
  localparam int CB_MDOUT = 7;
  localparam int CB_MDEN  = 6;
  localparam int CB_MCLK  = 5;
  localparam int CB_MDIN  = 4;
  localparam int CB_MODE  = 3;
  localparam int CB_SRST  = 2;
  localparam int CB_TXD   = 1;
  localparam int CB_FLAG  = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ARM,
    ST_ACK_HOLD,
    ST_RX,
    ST_TX,
    ST_TX_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic            scl_p, sda_p;
  logic            scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC-2:0], scl_i};
      sda_q <= {sda_q[SYNC-2:0], sda_i};
      scl_p <= scl_q[SYNC-1];
      sda_p <= sda_q[SYNC-1];
    end
  end

  assign scl_s    = scl_q[SYNC-1];
  assign sda_s    = sda_q[SYNC-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_periph_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] tx_byte,
  output logic          drv_low,
  output logic [DW-1:0] rx_byte,
  output logic          rx_valid,
  output logic          byte_done,
  output logic          tx_dir
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tgt_state_t    st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      drv_low   <= 1'b0;
      tx_dir    <= 1'b0;
      rx_valid  <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      byte_done <= 1'b0;
      if (start_ev) begin
        st      <= ST_ADDR;
        cnt     <= '0;
        drv_low <= 1'b0;
        tx_dir  <= 1'b0;
      end else if (stop_ev) begin
        st      <= ST_IDLE;
        drv_low <= 1'b0;
        tx_dir  <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            sh <= {sh[DW-2:0], sda_s};
            if (cnt == LAST) begin
              cnt <= '0;
              if (sh[AW-1:0] == own_addr) begin
                tx_dir <= sda_s;
                st     <= ST_ACK_ARM;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ACK_ARM: if (scl_fall) begin
            drv_low <= 1'b1;
            st      <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (scl_fall) begin
            cnt <= '0;
            if (tx_dir) begin
              sh      <= tx_byte;
              drv_low <= ~tx_byte[DW-1];
              st      <= ST_TX;
            end else begin
              drv_low <= 1'b0;
              st      <= ST_RX;
            end
          end
          ST_RX: if (scl_rise) begin
            sh <= {sh[DW-2:0], sda_s};
            if (cnt == LAST) begin
              cnt       <= '0;
              rx_valid  <= 1'b1;
              byte_done <= 1'b1;
              st        <= ST_ACK_ARM;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TX: if (scl_fall) begin
            if (cnt == LAST) begin
              cnt       <= '0;
              drv_low   <= 1'b0;
              byte_done <= 1'b1;
              st        <= ST_TX_ACK;
            end else begin
              cnt     <= cnt + 1'b1;
              drv_low <= ~sh[DW-2];
              sh      <= {sh[DW-2:0], 1'b0};
            end
          end
          ST_TX_ACK: if (scl_rise) begin
            if (sda_s) begin
              st     <= ST_IDLE;
              tx_dir <= 1'b0;
            end else begin
              st <= ST_ACK_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rx_byte = sh;
endmodule

// File: rtl/i2c_regs.sv
module i2c_regs
  import i2c_periph_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            AW      = 7,
  parameter logic [AW-1:0] OWN_RST = 7'h55
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_wr,
  input  logic            reg_rd,
  output logic [DW-1:0]   reg_rdata,
  input  logic            rx_valid,
  input  logic [DW-1:0]   rx_byte,
  input  logic            byte_done,
  input  logic            tx_dir,
  input  logic            scl_rise,
  input  logic            sda_s,
  output logic            m_sda_out,
  output logic            m_sda_en,
  output logic            m_scl_out,
  output logic            master_mode,
  output logic            soft_rst,
  output logic [AW-1:0]   own_addr,
  output logic [DW-1:0]   data_q,
  output logic            flag,
  output logic            data_acc
);
  logic m_sda_in;
  logic wr_ctrl;

  assign wr_ctrl  = reg_wr && (reg_addr == RA_CTRL);
  assign data_acc = (reg_wr || reg_rd) && (reg_addr == RA_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_sda_out   <= 1'b0;
      m_sda_en    <= 1'b0;
      m_scl_out   <= 1'b0;
      master_mode <= 1'b0;
      soft_rst    <= 1'b0;
      m_sda_in    <= 1'b0;
      own_addr    <= OWN_RST;
      data_q      <= '0;
      flag        <= 1'b0;
      reg_rdata   <= '0;
    end else begin
      if (wr_ctrl) begin
        m_sda_out   <= reg_wdata[CB_MDOUT];
        m_sda_en    <= reg_wdata[CB_MDEN];
        m_scl_out   <= reg_wdata[CB_MCLK];
        master_mode <= reg_wdata[CB_MODE];
        soft_rst    <= reg_wdata[CB_SRST];
      end
      if (master_mode && !m_sda_en && scl_rise) m_sda_in <= sda_s;
      if (reg_wr && reg_addr == RA_OWN) own_addr <= reg_wdata[AW-1:0];
      if (rx_valid) data_q <= rx_byte;
      else if (reg_wr && reg_addr == RA_DATA) data_q <= reg_wdata;
      if (byte_done) flag <= 1'b1;
      else if (data_acc) flag <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL: reg_rdata <= {m_sda_out, m_sda_en, m_scl_out, m_sda_in,
                                 master_mode, soft_rst, tx_dir, flag};
          RA_OWN:  reg_rdata <= DW'(own_addr);
          RA_DATA: reg_rdata <= data_q;
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_periph.sv
module i2c_periph
  import i2c_periph_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            AW      = 7,
  parameter logic [AW-1:0] OWN_RST = 7'h55,
  parameter int            SYNC    = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_wr,
  input  logic            reg_rd,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq,
  input  logic            scl_i,
  output logic            scl_oe,
  input  logic            sda_i,
  output logic            sda_oe
);
  logic          sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          m_sda_out, m_sda_en, m_scl_out, master_mode, soft_rst;
  logic [AW-1:0] own_addr;
  logic [DW-1:0] data_q, rx_byte;
  logic          drv_low, rx_valid, byte_done, tx_dir, data_acc;

  i2c_pin_sync #(.SYNC(SYNC)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_tgt_engine #(.DW(DW), .AW(AW)) u_eng (
    .clk(clk), .rst(rst), .hold(master_mode | soft_rst),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .own_addr(own_addr), .tx_byte(data_q),
    .drv_low(drv_low), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .byte_done(byte_done), .tx_dir(tx_dir)
  );

  i2c_regs #(.DW(DW), .AW(AW), .OWN_RST(OWN_RST)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .byte_done(byte_done),
    .tx_dir(tx_dir), .scl_rise(scl_rise), .sda_s(sda_s),
    .m_sda_out(m_sda_out), .m_sda_en(m_sda_en), .m_scl_out(m_scl_out),
    .master_mode(master_mode), .soft_rst(soft_rst), .own_addr(own_addr),
    .data_q(data_q), .flag(irq), .data_acc(data_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_oe <= 1'b0;
      scl_oe <= 1'b0;
    end else begin
      sda_oe <= master_mode ? (m_sda_en & ~m_sda_out) : drv_low;
      scl_oe <= master_mode & ~m_scl_out;
    end
  end
endmodule

// File: rtl/i2c_periph_chk.sv
module i2c_periph_chk (
  input logic clk,
  input logic rst,
  input logic master_mode,
  input logic soft_rst,
  input logic m_sda_en,
  input logic m_scl_out,
  input logic tx_dir,
  input logic byte_done,
  input logic data_acc,
  input logic irq,
  input logic scl_i,
  input logic sda_oe,
  input logic scl_oe
);
  AST_CTRL_SDA_RELEASE: assert property (@(posedge clk) disable iff (rst)
    master_mode && !m_sda_en |=> !sda_oe); // R3
  AST_CTRL_SCL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    master_mode && m_scl_out |=> !scl_oe); // R3
  AST_TGT_NO_SCL: assert property (@(posedge clk) disable iff (rst)
    !master_mode |=> !scl_oe); // R11
  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (rst)
    soft_rst && $past(soft_rst) && !master_mode |=> !sda_oe); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> irq); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    data_acc && !byte_done |=> !irq); // R9
  AST_TX_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !master_mode && !soft_rst && tx_dir && $past(tx_dir) && scl_i && $past(scl_i)
      |-> $stable(sda_oe)); // R8
endmodule

bind i2c_periph i2c_periph_chk u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode), .soft_rst(soft_rst),
  .m_sda_en(m_sda_en), .m_scl_out(m_scl_out), .tx_dir(tx_dir),
  .byte_done(byte_done), .data_acc(data_acc), .irq(irq),
  .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe)
);

// File: tb/test_i2c_periph.sv
module test_i2c_periph;
  localparam int H = 12;
  localparam int Q = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       m_sda_low = 1'b0, m_scl_low = 1'b0;
  logic       sda_line, scl_line;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;
  bit         tgt_phase = 1'b0;
  int         scl_pull_seen = 0;

  always #10 clk = ~clk;

  assign sda_line = ~(sda_oe | m_sda_low);
  assign scl_line = ~(scl_oe | m_scl_low);

  i2c_periph i_i2c_periph (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(negedge clk) if (tgt_phase && scl_oe) scl_pull_seen++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; m_scl_low = 1'b0; wait_clk(H);
    m_sda_low = 1'b1; wait_clk(H);
    m_scl_low = 1'b1;
  endtask

  task automatic bus_rstart();
    wait_clk(Q); m_sda_low = 1'b0; wait_clk(H);
    m_scl_low = 1'b0; wait_clk(H);
    m_sda_low = 1'b1; wait_clk(H);
    m_scl_low = 1'b1;
  endtask

  task automatic bus_stop();
    wait_clk(Q); m_sda_low = 1'b1; wait_clk(H);
    m_scl_low = 1'b0; wait_clk(H);
    m_sda_low = 1'b0; wait_clk(H);
  endtask

  task automatic send_bit(input logic b);
    wait_clk(Q); m_sda_low = ~b; wait_clk(H);
    m_scl_low = 1'b0; wait_clk(H);
    m_scl_low = 1'b1;
  endtask

  task automatic recv_bit(output logic b);
    wait_clk(Q); m_sda_low = 1'b0; wait_clk(H);
    m_scl_low = 1'b0; wait_clk(H/2);
    b = sda_line; wait_clk(H/2);
    m_scl_low = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) recv_bit(v[i]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] rd, v;
    logic       ack, dummy;
    logic [7:0] pats [7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C};
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);

    // R1 reset state
    reg_read(2'd0, rd); chk("R1 ctrl", rd, 8'h00);
    reg_read(2'd1, rd); chk("R1 own", rd, 8'h55);
    reg_read(2'd2, rd); chk("R1 data", rd, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 scl_oe", scl_oe, 0);

    // R2 hardware-owned control bits ignore writes
    reg_write(2'd0, 8'hFF); wait_clk(2);
    reg_read(2'd0, rd); chk("R2 ctrl ro bits", rd, 8'hEC);
    reg_write(2'd0, 8'h00); wait_clk(4);

    // R3 controller-mode pin sweep
    for (int k = 0; k < 8; k++) begin
      reg_write(2'd0, 8'((k << 5) | 8'h08)); wait_clk(2);
      chk("R3 sda_oe", sda_oe, int'(k[1] & ~k[2]));
      chk("R3 scl_oe", scl_oe, int'(~k[0] & 1));
    end

    // R4 data-line latch on clock rise
    for (int s = 0; s < 2; s++) begin
      m_sda_low = (s == 0);
      reg_write(2'd0, 8'h08); wait_clk(6);
      reg_write(2'd0, 8'h28); wait_clk(6);
      reg_read(2'd0, rd); chk("R4 latch", rd[4], s);
    end
    m_sda_low = 1'b1;
    reg_write(2'd0, 8'hC8); wait_clk(6);
    reg_write(2'd0, 8'hE8); wait_clk(6);
    reg_read(2'd0, rd); chk("R4 hold when enabled", rd[4], 1);
    m_sda_low = 1'b0;
    reg_write(2'd0, 8'h00); wait_clk(6);

    tgt_phase = 1'b1;
    // R6 address sweep over the full 7-bit space
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({7'(a), 1'b0}, ack);
      chk("R6 addr ack", ack, int'(a == 8'h55));
      bus_stop();
    end

    // R7 / R9 write bytes
    foreach (pats[i]) begin
      bus_start();
      send_byte({7'h55, 1'b0}, ack); chk("R6 ack write", ack, 1);
      send_byte(pats[i], ack);       chk("R7 data ack", ack, 1);
      chk("R9 irq after rx", irq, 1);
      bus_stop();
      reg_read(2'd2, rd); chk("R7 data stored", rd, pats[i]);
      chk("R9 irq cleared by read", irq, 0);
    end
    bus_start();
    send_byte({7'h55, 1'b0}, ack);
    send_byte(8'h11, ack);
    bus_stop();
    reg_read(2'd0, rd); chk("R9 flag in ctrl", rd[0], 1);
    reg_write(2'd2, 8'h22); wait_clk(1);
    chk("R9 irq cleared by write", irq, 0);

    // R8 / R9 read bytes
    foreach (pats[i]) begin
      reg_write(2'd2, pats[i]);
      bus_start();
      send_byte({7'h55, 1'b1}, ack); chk("R6 ack read", ack, 1);
      reg_read(2'd0, rd); chk("R8 dir during read", rd[1], 1);
      recv_byte(v); chk("R8 read value", v, pats[i]);
      wait_clk(Q + 4);
      chk("R9 irq after tx", irq, 1);
      send_bit(1'b1);
      bus_stop();
      reg_read(2'd0, rd); chk("R8 dir after nack", rd[1], 0);
      reg_read(2'd2, rd);
    end

    // R5 engine reset
    reg_write(2'd0, 8'h04);
    bus_start(); send_byte({7'h55, 1'b0}, ack); chk("R5 no ack in reset", ack, 0); bus_stop();
    reg_write(2'd0, 8'h00);
    bus_start(); send_byte({7'h55, 1'b0}, ack); chk("R5 ack after reset", ack, 1); bus_stop();

    // R10 repeated start mid-byte, and STOP to idle
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_rstart();
    send_byte({7'h55, 1'b0}, ack); chk("R10 ack after restart", ack, 1);
    bus_stop();
    send_byte({7'h55, 1'b0}, ack); chk("R10 no ack after stop", ack, 0);
    bus_stop();

    // R2 / R6 new own address
    reg_write(2'd1, 8'h23);
    reg_read(2'd1, rd); chk("R2 own readback", rd, 8'h23);
    bus_start(); send_byte({7'h23, 1'b0}, ack); chk("R6 new addr ack", ack, 1); bus_stop();
    bus_start(); send_byte({7'h55, 1'b0}, ack); chk("R6 old addr nack", ack, 0); bus_stop();
    dummy = 1'b0;
    tgt_phase = 1'b0;

    // R11 clock line never pulled in target mode
    chk("R11 scl pulls", scl_pull_seen + int'(dummy), 0);
    finish_run();
  end
endmodule